// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block generates the address that drives a memory array during four-beat burst accesses. A burst opens when either of two active-low address strobes is low at a rising clock edge. At that edge the whole external address and the ordering mode are captured, and a two-bit beat counter is cleared. On each later edge where the active-low advance input is low, the counter steps to the next beat.

The two low address bits are built from the captured start bits and the counter. Interleaved ordering XORs the start bits with the counter, so a start of 1 gives 1, 0, 3, 2. Linear ordering adds the counter to the start bits modulo four, so a start of 1 gives 1, 2, 3, 0. The bits above the low pair stay at their captured value for the whole burst. Gating the strobes with chip selects is done outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe applied, `array_addr` is all zeros.
- R2: When a strobe is low at a rising edge, `array_addr` equals the `addr_in` sampled at that edge from that edge on.
- R3: Either strobe alone (`strb_proc_n` or `strb_ctrl_n`) starts a burst. Both low together also start exactly one burst.
- R4: When `burst_lin` was 0 at the burst start, each edge with `adv_n` low and no strobe steps the beat counter. The low two bits of `array_addr` then equal the start bits XOR the counter.
- R5: When `burst_lin` was 1 at the burst start, the low two bits equal (start bits + counter) mod 4 at every beat.
- R6: The counter is two bits wide. After four advances the low bits return to the start bits.
- R7: An edge with both strobes and `adv_n` high leaves `array_addr` unchanged.
- R8: A strobe at the same edge as a low `adv_n` wins. The burst restarts at the new `addr_in` with the counter cleared.
- R9: `array_addr[ADDR_W-1:2]` keeps its captured value across advances and holds, and changes only at a strobe.
- R10: The ordering mode is sampled only at a strobe edge. Changing `burst_lin` during a burst has no effect on the ordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_proc_n | input | 1 | First burst-start strobe, active low |
| strb_ctrl_n | input | 1 | Second burst-start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| burst_lin | input | 1 | Ordering mode: 1 = linear, 0 = interleaved. Sampled at burst start |
| addr_in | input | ADDR_W | External start address |
| array_addr | output | ADDR_W | Address presented to the memory array |

## Verification
All state sits in registers, and `array_addr` is formed combinationally from them. Every result is therefore due at the first rising edge after the stimulus is applied, and it stays visible until the next edge. The driver applies inputs on the falling edge and pushes the expected address for the coming rising edge. The monitor pops and compares 2 ns after that rising edge, so each check lands in the cycle where the register update appears.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits for a given beat: interleaved XOR or linear wrapping add
  function automatic beat_t beat_low(beat_t start, beat_t cnt, logic lin);
    beat_t r;
    if (lin) r = start + cnt;
    else     r = start ^ cnt;
    return r;
  endfunction

  function automatic beat_t beat_next(beat_t cnt);
    return cnt + beat_t'(1);
  endfunction
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else if (step) cnt <= beat_next(cnt);
  end

  p_load_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0));
  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (cnt == beat_t'($past(cnt) + 2'd1)));
  p_hold_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt));
endmodule

// File: rtl/burst_start_capture.sv
module burst_start_capture #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              lin_in,
  output logic [ADDR_W-1:0] base,
  output logic              lin_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      lin_q <= 1'b0;
    end else if (load) begin
      base  <= addr_in;
      lin_q <= lin_in;
    end
  end

  p_base_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base));
  p_mode_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lin_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] array_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  // named internal events
  logic              ev_load;
  logic              ev_step;
  beat_t             cnt;
  logic [ADDR_W-1:0] base;
  logic              lin_q;
  beat_t             low_bits;

  assign ev_load = !strb_proc_n || !strb_ctrl_n;
  assign ev_step = !adv_n;

  burst_start_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .addr_in(addr_in),
    .lin_in(burst_lin), .base(base), .lin_q(lin_q)
  );

  burst_beat_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .step(ev_step), .cnt(cnt)
  );

  assign low_bits   = beat_low(base[BEAT_W-1:0], cnt, lin_q);
  assign array_addr = {base[ADDR_W-1:BEAT_W], low_bits};

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (array_addr == $past(addr_in)));
  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load |=> (array_addr[ADDR_W-1:BEAT_W] == $past(array_addr[ADDR_W-1:BEAT_W])));
  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_step) |=> $stable(array_addr));
  initial begin
    if (HI_W < 1) $error("ADDR_W too small");
  end
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 19;

  logic clk = 0, rst_n = 0;
  logic sp_n = 1, sc_n = 1, adv_n = 1, lin = 0;
  logic [AW-1:0] ain = '0;
  logic [AW-1:0] aout;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [AW-1:0] val; string req; } exp_t;
  exp_t q[$];

  // bench model
  logic [AW-1:0] m_base = '0;
  int m_cnt = 0;
  bit m_lin = 0;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .strb_proc_n(sp_n), .strb_ctrl_n(sc_n),
    .adv_n(adv_n), .burst_lin(lin), .addr_in(ain), .array_addr(aout)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] model_addr();
    int s, lo;
    s = int'(m_base[1:0]);
    if (m_lin) lo = (s + m_cnt) % 4;
    else lo = ((s / 2) != (m_cnt / 2) ? 2 : 0) + ((s % 2) != (m_cnt % 2) ? 1 : 0);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(logic [AW-1:0] act, logic [AW-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit p, bit c, bit a, bit l, logic [AW-1:0] addr, string req);
    exp_t e;
    @(negedge clk);
    sp_n = ~p; sc_n = ~c; adv_n = ~a; lin = l; ain = addr;
    if (p || c) begin m_base = addr; m_cnt = 0; m_lin = l; end
    else if (a) m_cnt = (m_cnt + 1) % 4;
    e.val = model_addr(); e.req = req;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(aout, e.val, e.req);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(aout, '0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2 check(aout, '0, "R1 after reset");

    // interleaved via first strobe, start 1: 1,0,3,2, wrap to 1
    step(1,0,0,0, 19'h12345, "R2 R3 proc strobe load");
    step(0,0,1,0, '0, "R4 interleaved beat1");
    step(0,0,1,1, '0, "R4 R10 interleaved beat2 mode change");
    step(0,0,1,0, '0, "R4 R9 interleaved beat3");
    step(0,0,1,0, '0, "R6 wrap interleaved");
    step(0,0,0,1, 19'h7FFFF, "R7 hold");
    step(0,0,0,0, 19'h00000, "R7 R9 hold again");

    // linear via second strobe, start 1: 1,2,3,0
    step(0,1,0,1, 19'h2AAA9, "R2 R3 ctrl strobe load");
    step(0,0,1,0, '0, "R5 linear beat1 R10");
    step(0,0,1,0, '0, "R5 linear beat2");
    step(0,0,1,1, '0, "R5 R9 linear beat3");
    step(0,0,1,1, '0, "R6 wrap linear");

    // linear start 3: 3,0,1,2
    step(1,0,0,1, 19'h55557, "R2 linear start3");
    step(0,0,1,1, '0, "R5 linear carry wrap");
    step(0,0,0,1, '0, "R7 hold linear");
    step(0,0,1,1, '0, "R5 linear beat2");

    // strobe with advance: restart wins
    step(1,0,1,0, 19'h0F0F2, "R8 strobe beats advance");
    step(0,0,1,0, '0, "R4 interleaved start2 beat1");
    step(0,1,1,1, 19'h33330, "R8 ctrl strobe beats advance");
    step(1,1,0,0, 19'h44446, "R3 both strobes");
    step(0,0,1,1, '0, "R10 interleaved kept");
    step(0,0,0,0, '0, "R7 final hold");

    @(negedge clk); sp_n = 1; sc_n = 1; adv_n = 1;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule